// File: doc/BRIEF.md
# Asynchronous Bus Master Sequencer

This block lets a microcoded processor take ownership of an asynchronous backplane bus and run single read or write cycles on it. Each clock the microcode presents a seven-bit command word. Its bits ask for the bus, give the bus back, choose read or write, launch a transfer, pick the byte lanes and clear a latched error. The block handles the request/grant arbitration and the strobe/acknowledge handshake with the addressed slave. It returns only simple status flags, which the microprogram sequencer tests as branch conditions.

Ownership lasts across any number of transfers until the microcode releases it. The bus grant, slave acknowledge and bus error inputs come from another timing domain, so each passes through a two-flop synchronizer before use. A transfer takes as many cycles as the slave needs. There is no timeout.

Command word bits: bit 0 request bus, bit 1 release bus, bit 2 direction (1 = read, 0 = write), bit 3 start transfer, bit 4 lower byte strobe, bit 5 upper byte strobe, bit 6 clear error.

Top module: `bms_top`

## Requirements
- R1: After reset, bus_req_o, bus_busy_o, as_o, ds_o, data_oe_o, granted_o, xfer_busy_o, done_o and err_o are all 0.
- R2: A command with bit 0 set while the bus is not owned raises bus_req_o on the next clock. bus_req_o stays high, and granted_o stays low, for as long as no grant is seen.
- R3: Once a grant is seen, bus_req_o falls and bus_busy_o and granted_o rise together. They stay high through every transfer until a release is accepted.
- R4: A start command (bit 3) launches a transfer only while the bus is owned and no transfer is in progress. At any other time as_o stays low.
- R5: A transfer begins with exactly one cycle in which as_o is high, ds_o is zero and addr_o and write_o (1 = write) hold the command's values. addr_o stays stable while as_o is high.
- R6: After the address cycle, ds_o carries the command's strobe bits (bit 4 to ds_o[0], bit 5 to ds_o[1]). The strobes stay asserted, unchanged, for as long as the slave has not acknowledged.
- R7: On a read, rdata_o takes data_i when the acknowledge is seen and data_oe_o stays low. On a write, data_oe_o is high and data_o holds the write data from the address cycle until the strobes drop.
- R8: After the acknowledge, as_o and ds_o drop. done_o pulses for exactly one cycle, on the third clock after the slave removes its acknowledge. done_o stays low while the acknowledge is still held.
- R9: A release (bit 1) is ignored while a transfer is in progress. When no transfer is in progress, a release drops bus_busy_o and granted_o on the next clock.
- R10: A bus error ends the data phase like an acknowledge and sets err_o, which stays set until a command with bit 6 clears it. done_o still pulses when the error input drops.
- R11: The inputs bus_grant_i, dtack_i and berr_i pass through two flops. granted_o rises on the third clock edge after bus_grant_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ucmd_i | input | 7 | Microcode command word |
| addr_i | input | AW | Address for a started transfer |
| wdata_i | input | DW | Write data for a started transfer |
| bus_req_o | output | 1 | Bus request line |
| bus_grant_i | input | 1 | Bus grant line (asynchronous) |
| bus_busy_o | output | 1 | Bus ownership line |
| as_o | output | 1 | Address strobe |
| ds_o | output | 2 | Byte lane data strobes |
| write_o | output | 1 | Direction, 1 = write |
| addr_o | output | AW | Bus address |
| data_o | output | DW | Bus write data |
| data_oe_o | output | 1 | Write data drive enable |
| data_i | input | DW | Bus read data |
| dtack_i | input | 1 | Slave acknowledge (asynchronous) |
| berr_i | input | 1 | Bus error (asynchronous) |
| granted_o | output | 1 | Status: bus owned |
| xfer_busy_o | output | 1 | Status: transfer in progress |
| done_o | output | 1 | Status: one-cycle end of transfer pulse |
| err_o | output | 1 | Status: sticky bus error |
| rdata_o | output | DW | Last read data |

## Verification
The hardest situation to reach is a release command that arrives while the strobes are out and the slave has not yet acknowledged. The block must drop that release, keep ownership and still finish the transfer cleanly. The bench issues the release in the first cycle of the data phase and holds the acknowledge off for several cycles. After the done pulse it checks that the bus is still owned. It also holds the acknowledge for several cycles after the strobes fall, to show that done waits for the slave to let go. It checks the synchronizer latency cycle by cycle.

// File: rtl/bms_pkg.sv
package bms_pkg;
    localparam int CMD_W  = 7;
    localparam int CB_REQ = 0;
    localparam int CB_REL = 1;
    localparam int CB_RD  = 2;
    localparam int CB_GO  = 3;
    localparam int CB_DS0 = 4;
    localparam int CB_DS1 = 5;
    localparam int CB_CLR = 6;

    typedef enum logic [1:0] {OWN_IDLE, OWN_REQ, OWN_HOLD} own_st_e;
    typedef enum logic [1:0] {XF_IDLE, XF_ADDR, XF_STRB, XF_REL} xf_st_e;
endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] s_o
);
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], a_i[g]};
        end
        assign s_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/bms_own.sv
module bms_own
    import bms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_cmd,
    input  logic rel_cmd,
    input  logic xfer_quiet,
    input  logic grant_s,
    output logic bus_req_o,
    output logic bus_busy_o
);
    typedef struct packed {
        own_st_e st;
        logic    req;
        logic    busy;
    } own_t;

    own_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            OWN_IDLE: if (req_cmd) begin
                d.st  = OWN_REQ;
                d.req = 1'b1;
            end
            OWN_REQ: if (grant_s) begin
                d.st   = OWN_HOLD;
                d.req  = 1'b0;
                d.busy = 1'b1;
            end
            OWN_HOLD: if (rel_cmd && xfer_quiet) begin
                d.st   = OWN_IDLE;
                d.busy = 1'b0;
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req_o  = q.req;
    assign bus_busy_o = q.busy;

    AST_REQ_NOT_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_o && bus_busy_o)); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !grant_s |=> bus_req_o); // R2
    AST_NO_RELEASE_MID_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_o && !xfer_quiet |=> bus_busy_o); // R9
endmodule

// File: rtl/bms_xfer.sv
module bms_xfer
    import bms_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_cmd,
    input  logic          rd_cmd,
    input  logic [1:0]    ds_cmd,
    input  logic          clr_cmd,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          owned,
    input  logic          ack_s,
    input  logic          berr_s,
    input  logic [DW-1:0] data_i,
    output logic          as_o,
    output logic [1:0]    ds_o,
    output logic          write_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          err_o,
    output logic          idle_o
);
    typedef struct packed {
        xf_st_e        st;
        logic          as;
        logic [1:0]    ds;
        logic [1:0]    ds_lat;
        logic          wr;
        logic          oe;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
        logic          err;
    } xf_t;

    xf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (clr_cmd) d.err = 1'b0;
        case (q.st)
            XF_IDLE: if (start_cmd && owned) begin
                d.st     = XF_ADDR;
                d.as     = 1'b1;
                d.addr   = addr_i;
                d.wr     = !rd_cmd;
                d.oe     = !rd_cmd;
                d.wdata  = wdata_i;
                d.ds_lat = ds_cmd;
            end
            XF_ADDR: begin
                d.st = XF_STRB;
                d.ds = q.ds_lat;
            end
            XF_STRB: if (berr_s || ack_s) begin
                d.st = XF_REL;
                d.as = 1'b0;
                d.ds = 2'b00;
                d.oe = 1'b0;
                if (berr_s)          d.err   = 1'b1;
                else if (!q.wr)      d.rdata = data_i;
            end
            XF_REL: if (!ack_s && !berr_s) begin
                d.st   = XF_IDLE;
                d.done = 1'b1;
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign as_o      = q.as;
    assign ds_o      = q.ds;
    assign write_o   = q.wr;
    assign addr_o    = q.addr;
    assign data_o    = q.wdata;
    assign data_oe_o = q.oe;
    assign rdata_o   = q.rdata;
    assign done_o    = q.done;
    assign err_o     = q.err;
    assign idle_o    = (q.st == XF_IDLE);

    AST_STRB_UNDER_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o != 2'b00) |-> as_o); // R5
    AST_AS_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |-> owned); // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |=> (!as_o || $stable(addr_o))); // R5
    AST_STRB_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o != 2'b00) && !ack_s && !berr_s |=> $stable(ds_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !clr_cmd |=> err_o); // R10
endmodule

// File: rtl/bms_top.sv
module bms_top
    import bms_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] ucmd_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             bus_req_o,
    input  logic             bus_grant_i,
    output logic             bus_busy_o,
    output logic             as_o,
    output logic [1:0]       ds_o,
    output logic             write_o,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    data_o,
    output logic             data_oe_o,
    input  logic [DW-1:0]    data_i,
    input  logic             dtack_i,
    input  logic             berr_i,
    output logic             granted_o,
    output logic             xfer_busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [DW-1:0]    rdata_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_s;
    logic             grant_s, ack_s, berr_s;
    logic             idle, quiet, start_cmd;

    bms_sync #(.W(NSYNC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   ({berr_i, dtack_i, bus_grant_i}),
        .s_o   (sync_s)
    );
    assign grant_s = sync_s[0];
    assign ack_s   = sync_s[1];
    assign berr_s  = sync_s[2];

    assign start_cmd = ucmd_i[CB_GO];
    assign quiet     = idle && !start_cmd;

    bms_own u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_cmd    (ucmd_i[CB_REQ]),
        .rel_cmd    (ucmd_i[CB_REL]),
        .xfer_quiet (quiet),
        .grant_s    (grant_s),
        .bus_req_o  (bus_req_o),
        .bus_busy_o (bus_busy_o)
    );

    bms_xfer #(.AW(AW), .DW(DW)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .rd_cmd    (ucmd_i[CB_RD]),
        .ds_cmd    ({ucmd_i[CB_DS1], ucmd_i[CB_DS0]}),
        .clr_cmd   (ucmd_i[CB_CLR]),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .owned     (bus_busy_o),
        .ack_s     (ack_s),
        .berr_s    (berr_s),
        .data_i    (data_i),
        .as_o      (as_o),
        .ds_o      (ds_o),
        .write_o   (write_o),
        .addr_o    (addr_o),
        .data_o    (data_o),
        .data_oe_o (data_oe_o),
        .rdata_o   (rdata_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .idle_o    (idle)
    );

    assign granted_o   = bus_busy_o;
    assign xfer_busy_o = !idle;
endmodule

// File: tb/sim_bms_top.sv
module sim_bms_top;
    localparam int CLK_P = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam logic [6:0] C_REQ = 7'h01, C_REL = 7'h02, C_RD = 7'h04,
                           C_GO = 7'h08, C_CLR = 7'h40;

    logic clk = 0, rst_n = 0;
    logic [6:0] ucmd = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0, din = '0;
    logic grant = 0, dtack = 0, berr = 0;
    logic bus_req, bus_busy, as_w, write_w, oe_w, granted, xbusy, done, err;
    logic [1:0] ds_w;
    logic [AW-1:0] addr_w;
    logic [DW-1:0] dout_w, rdata_w;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    bms_top #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ucmd_i(ucmd), .addr_i(addr), .wdata_i(wdata),
        .bus_req_o(bus_req), .bus_grant_i(grant), .bus_busy_o(bus_busy),
        .as_o(as_w), .ds_o(ds_w), .write_o(write_w), .addr_o(addr_w),
        .data_o(dout_w), .data_oe_o(oe_w), .data_i(din), .dtack_i(dtack),
        .berr_i(berr), .granted_o(granted), .xfer_busy_o(xbusy),
        .done_o(done), .err_o(err), .rdata_o(rdata_w)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic issue(input logic [6:0] c);
        @(negedge clk); ucmd = c;
        @(negedge clk); ucmd = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk({bus_req, bus_busy, as_w, ds_w, oe_w, granted, xbusy, done, err} == 0,
            "R1 reset outputs", {bus_req, bus_busy, as_w, ds_w, oe_w, granted, xbusy, done, err}, 0);
        rst_n = 1;
    endtask

    task automatic t_not_owned(input string tag);
        addr = 24'h000123;
        issue(C_GO | 7'h30);
        for (int i = 0; i < 8; i++) begin
            chk(as_w == 0 && xbusy == 0, tag, as_w, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_arbitrate();
        issue(C_REQ);
        chk(bus_req == 1, "R2 request raised", bus_req, 1);
        repeat (10) @(negedge clk);
        chk(bus_req == 1 && granted == 0, "R2 request held without grant", {bus_req, granted}, 2'b10);
        grant = 1;
        @(negedge clk); chk(granted == 0, "R11 no grant after 1 edge", granted, 0);
        @(negedge clk); chk(granted == 0, "R11 no grant after 2 edges", granted, 0);
        @(negedge clk); chk(granted == 1, "R11 grant after 3 edges", granted, 1);
        chk(bus_req == 0 && bus_busy == 1, "R3 ownership taken", {bus_req, bus_busy}, 2'b01);
    endtask

    task automatic run_xfer(input bit rd, input logic [1:0] ds, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                            input int dly, input bit use_berr, input bit rel_mid);
        bit got;
        addr = a; wdata = wd;
        issue((rd ? C_RD : 7'h00) | C_GO | {1'b0, ds, 4'h0});
        chk(as_w == 1 && ds_w == 0, "R5 address cycle", {as_w, ds_w}, 3'b100);
        chk(addr_w == a && write_w == !rd, "R5 address and direction", {addr_w, write_w}, {a, !rd});
        chk(oe_w == !rd, "R7 drive enable in address cycle", oe_w, !rd);
        if (!rd) chk(dout_w == wd, "R7 write data", dout_w, wd);
        @(negedge clk);
        chk(ds_w == ds && as_w == 1, "R6 strobes follow command", ds_w, ds);
        for (int i = 0; i < dly; i++) begin
            ucmd = (rel_mid && i == 0) ? C_REL : 7'h00;
            @(negedge clk);
            chk(ds_w == ds && done == 0, "R6 strobes held awaiting slave", ds_w, ds);
        end
        ucmd = '0;
        din = rv;
        if (use_berr) berr = 1; else dtack = 1;
        got = 0;
        for (int i = 0; i < 10 && !got; i++) begin
            @(negedge clk);
            if (ds_w == 0) got = 1;
        end
        chk(got && as_w == 0 && oe_w == 0, "R8 strobes released after acknowledge", {as_w, ds_w, oe_w}, 0);
        if (rd && !use_berr) chk(rdata_w == rv, "R7 read capture", rdata_w, rv);
        if (use_berr) chk(err_o_val() == 1, "R10 error flagged", err, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(done == 0 && xbusy == 1, "R8 done waits for slave release", done, 0);
        end
        dtack = 0; berr = 0;
        @(negedge clk); chk(done == 0, "R8 done not after 1 edge", done, 0);
        @(negedge clk); chk(done == 0, "R8 done not after 2 edges", done, 0);
        @(negedge clk); chk(done == 1, "R8 done after 3 edges", done, 1);
        @(negedge clk); chk(done == 0 && xbusy == 0, "R8 done one cycle", done, 0);
        chk(granted == 1 && bus_busy == 1, rel_mid ? "R9 release ignored mid transfer" : "R3 ownership kept",
            granted, 1);
    endtask

    function automatic logic err_o_val();
        return err;
    endfunction

    task automatic t_error();
        run_xfer(1, 2'b11, 24'h00BEEF, '0, 16'h1111, 2, 1, 0);
        repeat (5) @(negedge clk);
        chk(err == 1, "R10 error is sticky", err, 1);
        issue(C_CLR);
        chk(err == 0, "R10 error cleared", err, 0);
    endtask

    task automatic t_release();
        issue(C_REL);
        chk(bus_busy == 0 && granted == 0 && bus_req == 0, "R9 release accepted when idle",
            {bus_busy, granted, bus_req}, 0);
        grant = 0;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=expired expected=finish");
        summary();
    end

    initial begin
        t_reset();
        t_not_owned("R4 start ignored before ownership");
        t_arbitrate();
        run_xfer(0, 2'b11, 24'h12_3456, 16'hC0DE, '0, 4, 0, 0);
        run_xfer(1, 2'b01, 24'h00_0010, '0, 16'hA5C3, 3, 0, 0);
        run_xfer(1, 2'b10, 24'hFF_FFFE, '0, 16'h5A3C, 6, 0, 1);
        t_error();
        run_xfer(0, 2'b01, 24'h00_0002, 16'h0042, '0, 1, 0, 0);
        chk(err == 0, "R10 clean transfer after clear", err, 0);
        t_release();
        t_not_owned("R4 start ignored after release");
        summary();
    end
endmodule